// File: doc/BRIEF.md
# Interrupt-Pending Register with Merged External Line

This block holds the machine-level interrupt-pending register of a processor core. Most of its bits are plain storage that software can write. Bits outside the implemented mask always read as zero. One bit, at position 9, is special. It combines a software-owned latch with a live line from the external interrupt controller. A read at that bit returns the OR of the latch and the line. Every read-modify-write update, however, starts from the latch alone. As a result, a real external interrupt can be reported without ever being copied into stored state. Software at a higher privilege level can then raise or drop a virtual external interrupt without hiding or erasing a real one.

The core drives one access at a time through a simple port. The port has a strobe, a two-bit operation code, a source operand, and a suppress flag. The core raises the suppress flag when a set or clear form carries a zero source. The block returns the pre-access value one cycle later. It also drives an effective pending vector to the interrupt arbiter, and this vector follows the external line combinationally.

Top module: `irq_pend_csr`

## Requirements
- R1: While reset is asserted, and right after it is released, the stored latch bits are zero. In that state `csr_rvalid` is 0, `csr_rdata` is 0, and `irq_pend_o` equals only the external line at bit 9.
- R2: An access sampled at a rising edge (`csr_valid`=1) raises `csr_rvalid` after that edge. Its `csr_rdata` is the register value as seen before the access at that edge.
- R3: Bit 9 of the returned read data is the OR of the bit-9 latch and `ext_irq`, both sampled at the access edge. This holds for every operation code.
- R4: Operation code 2'b01 (write) loads every implemented latch bit from the matching source bit. At bit 9 the result is `csr_wdata[9]`, whatever the value of `ext_irq`.
- R5: Operation code 2'b10 (set) ORs the masked source into the latches. At bit 9 the new latch is the old latch OR `csr_wdata[9]`, and `ext_irq` plays no part.
- R6: Operation code 2'b11 (clear) ANDs each implemented latch with the inverse of its source bit. `ext_irq` plays no part.
- R7: When `csr_wr_suppress` is 1, the access returns read data but leaves every latch unchanged.
- R8: `irq_pend_o` is the latch vector with bit 9 ORed with `ext_irq`. It is combinational, so a change of `ext_irq` shows without any access.
- R9: Bits outside the parameter `WMASK` (default bits 1, 5 and 9) read as zero and ignore writes.
- R10: Operation code 2'b00, and any cycle with `csr_valid`=0, leave the latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | Access strobe |
| csr_op | input | 2 | 00 read only, 01 write, 10 set, 11 clear |
| csr_wdata | input | W | Source operand |
| csr_wr_suppress | input | 1 | Read without modifying |
| ext_irq | input | 1 | Live external interrupt line |
| csr_rdata | output | W | Pre-access register value |
| csr_rvalid | output | 1 | Read data valid |
| irq_pend_o | output | W | Effective pending vector to the arbiter |

## Verification
Read data and its valid flag are due one cycle after the edge that samples the strobe. The latch update lands at that same edge, so the effective pending vector reflects it from then on. A change of the external line reaches the pending vector with no edge at all. The driver sets up inputs at the falling edge and queues the expected pre-access value. The monitor pops that value at the next falling edge, when the valid flag is high. Pending-vector checks are made at falling edges, after the inputs have settled. Several sequences raise the external line during set, write and clear operations and then read back with the line low. This proves the line never entered the latch.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic [1:0] {
    CSR_NOP = 2'b00,
    CSR_RW  = 2'b01,
    CSR_RS  = 2'b10,
    CSR_RC  = 2'b11
  } csr_op_e;
endpackage

// File: rtl/irq_pend_next.sv
module irq_pend_next
  import irq_pend_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic [W-1:0] cur_i,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] src_i,
  input  logic         suppress_i,
  output logic [W-1:0] nxt_o,
  output logic         we_o
);
  logic [W-1:0] src_m;
  csr_op_e      op;

  always_comb begin
    op    = csr_op_e'(op_i);
    src_m = src_i & WMASK;
    nxt_o = cur_i;
    we_o  = 1'b0;
    if (valid_i && !suppress_i) begin
      unique case (op)
        CSR_RW: begin
          nxt_o = src_m;
          we_o  = 1'b1;
        end
        CSR_RS: begin
          nxt_o = cur_i | src_m;
          we_o  = 1'b1;
        end
        CSR_RC: begin
          nxt_o = cur_i & ~src_m;
          we_o  = 1'b1;
        end
        default: begin
          nxt_o = cur_i;
          we_o  = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_pend_bits.sv
module irq_pend_bits #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (WMASK[i]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bit_q <= 1'b0;
        else if (we_i) bit_q <= d_i[i];
      end
      assign q_o[i] = bit_q;
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_pend_rdport.sv
module irq_pend_rdport #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [W-1:0] view_i,
  output logic [W-1:0] rdata_o,
  output logic         rvalid_o
);
  logic [W-1:0] rdata_d;
  logic         rvalid_d;

  always_comb begin
    rvalid_d = valid_i;
    rdata_d  = valid_i ? view_i : rdata_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rvalid_d;
      if (valid_i) rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/irq_pend_csr.sv
module irq_pend_csr #(
  parameter int unsigned W       = 32,
  parameter int unsigned EXT_POS = 9,
  parameter logic [W-1:0] WMASK  = 32'h0000_0222
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         csr_valid,
  input  logic [1:0]   csr_op,
  input  logic [W-1:0] csr_wdata,
  input  logic         csr_wr_suppress,
  input  logic         ext_irq,
  output logic [W-1:0] csr_rdata,
  output logic         csr_rvalid,
  output logic [W-1:0] irq_pend_o
);
  localparam logic [W-1:0] EXT_ONEHOT = W'(1) << EXT_POS;

  logic [W-1:0] sw_q;
  logic [W-1:0] sw_d;
  logic         sw_we;
  logic [W-1:0] merged;

  // Update path sees only the stored latches, never the external line.
  irq_pend_next #(.W(W), .WMASK(WMASK)) u_next (
    .cur_i      (sw_q),
    .valid_i    (csr_valid),
    .op_i       (csr_op),
    .src_i      (csr_wdata),
    .suppress_i (csr_wr_suppress),
    .nxt_o      (sw_d),
    .we_o       (sw_we)
  );

  irq_pend_bits #(.W(W), .WMASK(WMASK)) u_bits (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (sw_we),
    .d_i   (sw_d),
    .q_o   (sw_q)
  );

  assign merged     = sw_q | (ext_irq ? EXT_ONEHOT : '0);
  assign irq_pend_o = merged;

  irq_pend_rdport #(.W(W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (csr_valid),
    .view_i   (merged),
    .rdata_o  (csr_rdata),
    .rvalid_o (csr_rvalid)
  );
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int unsigned W       = 32,
  parameter int unsigned EXT_POS = 9,
  parameter logic [W-1:0] WMASK  = 32'h0000_0222
) (
  input logic         clk,
  input logic         rst_n,
  input logic         csr_valid,
  input logic [1:0]   csr_op,
  input logic [W-1:0] csr_wdata,
  input logic         csr_wr_suppress,
  input logic         ext_irq,
  input logic [W-1:0] csr_rdata,
  input logic         csr_rvalid,
  input logic [W-1:0] irq_pend_o,
  input logic [W-1:0] sw_q
);
  // R2
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid |=> csr_rvalid);

  // R3
  rd_bit_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid |=> csr_rdata[EXT_POS] == ($past(sw_q[EXT_POS]) | $past(ext_irq)));

  // R5
  set_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && !csr_wr_suppress && csr_op == 2'b10 && !sw_q[EXT_POS]
     && !csr_wdata[EXT_POS] && ext_irq) |=> !sw_q[EXT_POS]);

  // R7
  suppress_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_wr_suppress) |=> $stable(sw_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_valid || csr_op == 2'b00) |=> $stable(sw_q));

  // R8
  ext_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |-> irq_pend_o[EXT_POS]);

  // R9
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rvalid |-> (csr_rdata & ~WMASK) == '0);
endmodule

bind irq_pend_csr irq_pend_chk #(.W(W), .EXT_POS(EXT_POS), .WMASK(WMASK)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .csr_valid       (csr_valid),
  .csr_op          (csr_op),
  .csr_wdata       (csr_wdata),
  .csr_wr_suppress (csr_wr_suppress),
  .ext_irq         (ext_irq),
  .csr_rdata       (csr_rdata),
  .csr_rvalid      (csr_rvalid),
  .irq_pend_o      (irq_pend_o),
  .sw_q            (sw_q)
);

// File: tb/irq_pend_csr_bench.sv
`timescale 1ns/1ps
module irq_pend_csr_bench;
  localparam int unsigned W = 32;
  localparam logic [W-1:0] M = 32'h0000_0222;
  localparam logic [W-1:0] B9 = 32'h0000_0200;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         csr_valid = 1'b0;
  logic [1:0]   csr_op = 2'b00;
  logic [W-1:0] csr_wdata = '0;
  logic         csr_wr_suppress = 1'b0;
  logic         ext_irq = 1'b0;
  logic [W-1:0] csr_rdata;
  logic         csr_rvalid;
  logic [W-1:0] irq_pend_o;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] model_sw = '0;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  irq_pend_csr u_irq_pend_csr (
    .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_op(csr_op),
    .csr_wdata(csr_wdata), .csr_wr_suppress(csr_wr_suppress), .ext_irq(ext_irq),
    .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid), .irq_pend_o(irq_pend_o)
  );

  function automatic logic [W-1:0] apply_op(logic [W-1:0] cur, logic [1:0] op,
                                            logic [W-1:0] src, logic sup);
    if (sup) return cur;
    case (op)
      2'b01:   return src & M;
      2'b10:   return cur | (src & M);
      2'b11:   return cur & ~(src & M);
      default: return cur;
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one access per call, inputs changed at the falling edge.
  task automatic access(string tag, logic [1:0] op, logic [W-1:0] src,
                        logic sup, logic ext);
    exp_t e;
    @(negedge clk);
    ext_irq = ext;
    csr_valid = 1'b1;
    csr_op = op;
    csr_wdata = src;
    csr_wr_suppress = sup;
    e.exp = model_sw | (ext ? B9 : '0);
    e.tag = tag;
    sb.push_back(e);
    model_sw = apply_op(model_sw, op, src, sup);
  endtask

  task automatic idle(int n, logic [W-1:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      csr_valid = 1'b0;
      csr_op = 2'b11;
      csr_wdata = junk;
      csr_wr_suppress = 1'b0;
    end
  endtask

  task automatic chk_pend(string tag, logic ext);
    @(negedge clk);
    csr_valid = 1'b0;
    ext_irq = ext;
    #1;
    check(tag, irq_pend_o, model_sw | (ext ? B9 : '0));
  endtask

  // Monitor: pops the expected pre-access value when read data is valid.
  always @(negedge clk) begin
    if (rst_n && csr_rvalid) begin
      if (sb.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R2 actual=unexpected-rvalid expected=no-rvalid");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, csr_rdata, e.exp);
      end
    end
  end

  initial begin
    #2;
    check("R1 rdata in reset", csr_rdata, '0);
    check("R1 rvalid in reset", {31'b0, csr_rvalid}, '0);
    check("R1 pend in reset", irq_pend_o, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk_pend("R1 pend after reset", 1'b0);
    chk_pend("R8 ext raised without access", 1'b1);
    access("R5 set zero src with ext high", 2'b10, '0, 1'b0, 1'b1);
    access("R5 latch did not absorb ext", 2'b00, '0, 1'b0, 1'b0);
    access("R3 rw with ext high", 2'b01, 32'h0000_0222, 1'b0, 1'b1);
    access("R4 rw loaded latch", 2'b00, '0, 1'b0, 1'b0);
    access("R6 clear bit9", 2'b11, B9, 1'b0, 1'b0);
    access("R3 read merges ext after clear", 2'b00, '0, 1'b0, 1'b1);
    access("R7 suppressed set", 2'b10, '1, 1'b1, 1'b0);
    access("R7 value after suppressed set", 2'b00, '0, 1'b0, 1'b0);
    access("R9 rw all ones", 2'b01, '1, 1'b0, 1'b0);
    access("R9 unimplemented bits zero", 2'b00, '0, 1'b0, 1'b0);
    access("R7 suppressed clear", 2'b11, '1, 1'b1, 1'b1);
    access("R4 rw zero with ext high", 2'b01, '0, 1'b0, 1'b1);
    access("R4 latch cleared despite ext", 2'b00, '0, 1'b0, 1'b0);
    access("R5 set bit9 only", 2'b10, B9, 1'b0, 1'b0);
    access("R6 clear low bits with ext", 2'b11, 32'h0000_0022, 1'b0, 1'b1);
    access("R5 result of set", 2'b00, '0, 1'b0, 1'b0);
    idle(3, '1);
    chk_pend("R10 no strobe leaves latches", 1'b0);
    access("R10 nop with ones", 2'b00, '1, 1'b0, 1'b0);
    access("R10 after nop", 2'b00, '0, 1'b0, 1'b0);
    idle(2, '0);
    chk_pend("R8 pend with ext high", 1'b1);
    chk_pend("R8 pend with ext low", 1'b0);
    idle(2, '0);
    if (sb.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL R2 actual=%0d pending expected=0 pending", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule